// File: doc/BRIEF.md
# SPI Burst Register Access Target

This block is a serial target that lets a host read and write a byte-wide register file through a four-wire serial port. Each transfer runs inside one chip-select window. It opens with three header bytes: a command byte, the low address byte and then the high address byte. Data bytes follow at once. The command byte gives the direction in its top bit and the number of data bytes, minus one, in its lower seven bits.

The port works in clock mode 0 with the most significant bit first. The serial clock is assumed to be synchronous to the system clock and is sampled directly, with edges found by comparing it against its value on the previous system cycle. The 16-bit address advances after every data byte. Only addresses whose high part is zero reach the register file. The register storage sits outside the block, behind a simple strobe interface: a write strobe with address and data, and a read strobe with a combinational read-data return.

A host that keeps clocking past the declared count gets zero bytes back, and its extra write bytes are dropped. Raising chip select at any point abandons the transfer and clears the header parser, so the next window starts afresh.

Top module: `spi_burst_regif`

## Requirements
- R1: Bit 7 of the first header byte selects the direction: 1 makes the transfer a write, 0 makes it a read.
- R2: Bits 6:0 of the first header byte hold N-1, where N is the number of data bytes the transfer acts on (1 to 128).
- R3: The second header byte is address bits 7:0 and the third is address bits 15:8. Register index = address bits 7:0 when bits 15:8 are zero.
- R4: Mode 0, MSB first: mosi_i is taken on each rising sclk_i edge and miso_o changes only on falling edges. miso_o is 0 during all three header bytes and during write data.
- R5: Each in-range write data byte within the count gives exactly one single-cycle reg_we_o pulse carrying the received byte and the current address.
- R6: Each in-range read data byte within the count gives one single-cycle reg_re_o pulse and shifts out reg_rdata_i for the current address. The address then increments by one.
- R7: Data bytes past the declared count produce no strobe. On a write they change nothing; on a read they shift out 0x00.
- R8: Raising cs_ni at any point abandons the transfer, discards any partial byte and resets the parser, so the next window starts again at the command byte.
- R9: When address bits 15:8 are non-zero, including after an increment carries out of 0x00FF, writes are discarded and reads shift out 0xFF with no strobe.
- R10: While rst_ni is low, miso_o, reg_we_o and reg_re_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| reg_addr_o | output | REG_AW | Register index for read or write |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Register read data, combinational on reg_addr_o |

## Verification
The hardest situations to reach from the ports are an address that leaves the register file partway through a burst, and an abort that lands in the middle of a byte. Random headers almost never produce either. Directed transfers start at 0x00FE so the increment carries into the high byte, and the bench then checks both the number of strobes and the 0xFF fill. Other directed transfers raise chip select after a few bits of a header byte or of a data byte, and then confirm through a clean read-back that nothing leaked into the registers. A seeded random mix of directions, lengths, over-clocked tails and addresses then covers the normal paths against a bench-side register image.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned DIR_BIT = 7;   // command byte: 1 = write
  localparam int unsigned CNT_W   = 7;   // command byte: bytes minus one
  localparam int unsigned SPI_AW  = 16;  // wire address width

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ALO,
    PH_AHI,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/spi_sclk_edges.sv
module spi_sclk_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  assign rise_o = !cs_ni &&  sclk_i && !sclk_q;
  assign fall_o = !cs_ni && !sclk_i &&  sclk_q;
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_ni,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         mosi_i,
  input  logic [W-1:0] load_data_i,
  output logic         byte_done_o,
  output logic [W-1:0] byte_o,
  output logic         load_o,
  output logic         miso_o
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] bit_cnt_q;
  logic [W-1:0]  rx_q;
  logic [W-1:0]  tx_q;

  assign byte_done_o = rise_i && (bit_cnt_q == CW'(W - 1));
  assign byte_o      = {rx_q[W-2:0], mosi_i};
  assign load_o      = fall_i && (bit_cnt_q == '0);
  assign miso_o      = tx_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
    end else if (cs_ni) begin
      bit_cnt_q <= '0;
      tx_q      <= '0;
    end else begin
      if (rise_i) begin
        rx_q      <= {rx_q[W-2:0], mosi_i};
        bit_cnt_q <= (bit_cnt_q == CW'(W - 1)) ? '0 : bit_cnt_q + 1'b1;
      end
      if (load_o)      tx_q <= load_data_i;
      else if (fall_i) tx_q <= {tx_q[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_burst_ctrl.sv
module spi_burst_ctrl
  import spi_burst_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_re_o,
  output logic [BYTE_W-1:0] load_data_o
);
  phase_e              phase_q;
  logic                wr_q;
  logic                live_q;
  logic [CNT_W-1:0]    left_q;
  logic [SPI_AW-1:0]   addr_q;
  logic                we_q;
  logic [BYTE_W-1:0]   wdata_q;
  logic [REG_AW-1:0]   waddr_q;
  logic                in_range;
  logic                rd_phase;
  logic [BYTE_W-1:0]   rd_val;

  assign in_range = (addr_q >> REG_AW) == '0;
  assign rd_phase = (phase_q == PH_DATA) && !wr_q;

  always_comb begin
    if (!live_q)       rd_val = '0;
    else if (in_range) rd_val = reg_rdata_i;
    else               rd_val = '1;
  end

  assign load_data_o = rd_phase ? rd_val : '0;
  assign reg_re_o    = load_i && rd_phase && live_q && in_range;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_addr_o  = we_q ? waddr_q : addr_q[REG_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      wr_q    <= 1'b0;
      live_q  <= 1'b0;
      left_q  <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      waddr_q <= '0;
    end else if (cs_ni) begin
      phase_q <= PH_CMD;
      live_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (byte_done_i) begin
        unique case (phase_q)
          PH_CMD: begin
            wr_q    <= byte_i[DIR_BIT];
            left_q  <= byte_i[CNT_W-1:0];
            live_q  <= 1'b1;
            phase_q <= PH_ALO;
          end
          PH_ALO: begin
            addr_q[7:0] <= byte_i;
            phase_q     <= PH_AHI;
          end
          PH_AHI: begin
            addr_q[SPI_AW-1:8] <= byte_i;
            phase_q            <= PH_DATA;
          end
          default: begin
            if (live_q) begin
              we_q    <= wr_q && in_range;
              wdata_q <= byte_i;
              waddr_q <= addr_q[REG_AW-1:0];
              addr_q  <= addr_q + SPI_AW'(1);
              if (left_q == '0) live_q <= 1'b0;
              else              left_q <= left_q - 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_burst_regif.sv
module spi_burst_regif
  import spi_burst_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_re_o,
  input  logic [7:0]        reg_rdata_i
);
  logic              rise, fall;
  logic              byte_done, load;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  spi_sclk_edges u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .sclk_i (sclk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .mosi_i      (mosi_i),
    .load_data_i (tx_byte),
    .byte_done_o (byte_done),
    .byte_o      (rx_byte),
    .load_o      (load),
    .miso_o      (miso_o)
  );

  spi_burst_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .load_i      (load),
    .reg_rdata_i (reg_rdata_i),
    .reg_addr_o  (reg_addr_o),
    .reg_we_o    (reg_we_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_re_o    (reg_re_o),
    .load_data_o (tx_byte)
  );
endmodule

// File: rtl/spi_burst_regif_chk.sv
module spi_burst_regif_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sclk_i,
  input logic miso_o,
  input logic reg_we_o,
  input logic reg_re_o
);
  logic sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_i;
  end

  assert_we_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_re_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o);

  assert_cs_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (!reg_we_o && !miso_o));

  assert_miso_fall_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !(!sclk_i && sclk_d)) |=> $stable(miso_o));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R10: assert (!miso_o && !reg_we_o && !reg_re_o);
    end
  end
endmodule

bind spi_burst_regif spi_burst_regif_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .sclk_i   (sclk_i),
  .miso_o   (miso_o),
  .reg_we_o (reg_we_o),
  .reg_re_o (reg_re_o)
);

// File: tb/spi_burst_regif_test.sv
`timescale 1ns/1ps
module spi_burst_regif_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic [7:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic       reg_re;
  logic [7:0] reg_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int we_cnt  = 0;
  int re_cnt  = 0;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic [7:0] tx_buf  [16];
  logic [7:0] rx_buf  [16];
  logic [7:0] hdr_rx  [3];

  always #2.5 clk = ~clk;

  spi_burst_regif uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cs_ni       (cs_n),
    .sclk_i      (sclk),
    .mosi_i      (mosi),
    .miso_o      (miso),
    .reg_addr_o  (reg_addr),
    .reg_we_o    (reg_we),
    .reg_wdata_o (reg_wdata),
    .reg_re_o    (reg_re),
    .reg_rdata_i (reg_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  // bench-side register storage
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) we_cnt <= we_cnt + 1;
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      half();
      q[i] = miso;
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
  endtask

  task automatic partial_bits(input int nb);
    for (int i = 0; i < nb; i++) begin
      mosi = 1'b1;
      half();
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
  endtask

  task automatic run_txn(input bit wr, input int cm1, input logic [15:0] addr, input int nbytes);
    logic [7:0] q;
    cs_n = 1'b0;
    half();
    xfer({wr, 7'(cm1)}, q); hdr_rx[0] = q;
    xfer(addr[7:0], q);     hdr_rx[1] = q;
    xfer(addr[15:8], q);    hdr_rx[2] = q;
    for (int k = 0; k < nbytes; k++) begin
      xfer(tx_buf[k], q);
      rx_buf[k] = q;
    end
    half();
    cs_n = 1'b1;
    half();
  endtask

  function automatic bit hit(int k, int cm1, logic [15:0] addr);
    logic [15:0] a;
    a = addr + 16'(k);
    return (k <= cm1) && (a[15:8] == 8'h00);
  endfunction

  function automatic logic [7:0] exp_rd(int k, int cm1, logic [15:0] addr);
    logic [15:0] a;
    a = addr + 16'(k);
    if (k > cm1)            return 8'h00;
    else if (a[15:8] != 0)  return 8'hFF;
    else                    return exp_mem[a[7:0]];
  endfunction

  function automatic string tag_of(int k, int cm1, logic [15:0] addr);
    logic [15:0] a;
    a = addr + 16'(k);
    if (k > cm1)           return "R7";
    else if (a[15:8] != 0) return "R9";
    else                   return "R6";
  endfunction

  // full write then bookkeeping of expected image and strobe count
  task automatic do_write(input int cm1, input logic [15:0] addr, input int nbytes, input string req);
    int w0, nexp;
    w0 = we_cnt;
    nexp = 0;
    run_txn(1'b1, cm1, addr, nbytes);
    for (int k = 0; k < nbytes; k++) begin
      if (hit(k, cm1, addr)) begin
        exp_mem[8'(addr + 16'(k))] = tx_buf[k];
        nexp++;
      end
      check(rx_buf[k] == 8'h00, "R4 write data miso", int'(rx_buf[k]), 0);
    end
    check(we_cnt - w0 == nexp, req, we_cnt - w0, nexp);
  endtask

  task automatic do_read(input int cm1, input logic [15:0] addr, input int nbytes);
    int r0, nexp;
    r0 = re_cnt;
    nexp = 0;
    for (int k = 0; k < nbytes; k++) tx_buf[k] = 8'h00;
    run_txn(1'b0, cm1, addr, nbytes);
    for (int k = 0; k < 3; k++)
      check(hdr_rx[k] == 8'h00, "R4 header miso", int'(hdr_rx[k]), 0);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] e;
      e = exp_rd(k, cm1, addr);
      check(rx_buf[k] == e, tag_of(k, cm1, addr), int'(rx_buf[k]), int'(e));
      if (hit(k, cm1, addr)) nexp++;
    end
    check(re_cnt - r0 == nexp, "R6 read strobe count", re_cnt - r0, nexp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    repeat (4) @(negedge clk);
    // R10 reset state
    check(!miso && !reg_we && !reg_re, "R10 reset idle", int'({miso, reg_we, reg_re}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!miso && !reg_we && !reg_re, "R10 after reset", int'({miso, reg_we, reg_re}), 0);

    // R1 R2 R3 R5: directed four-byte write, then read back
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33; tx_buf[3] = 8'h44;
    do_write(3, 16'h0010, 4, "R5 write strobes R1 R2 R3");
    do_read(3, 16'h0010, 4);
    do_read(0, 16'h0013, 1);  // R2 count of one

    // R7: over-clocked write and read
    tx_buf[0] = 8'hC1; tx_buf[1] = 8'hC2; tx_buf[2] = 8'hC3; tx_buf[3] = 8'hC4;
    do_write(1, 16'h0080, 4, "R7 write strobes beyond count");
    do_read(3, 16'h0080, 4);
    do_read(1, 16'h0080, 5);

    // R9: high address byte non-zero, and carry out of 0x00FF
    tx_buf[0] = 8'h99; tx_buf[1] = 8'h98;
    do_write(1, 16'h0120, 2, "R9 out-of-range write strobes");
    do_read(1, 16'h0020, 2);
    do_read(1, 16'h0120, 2);
    tx_buf[0] = 8'hE0; tx_buf[1] = 8'hE1; tx_buf[2] = 8'hE2;
    do_write(2, 16'h00FE, 3, "R9 carry write strobes");
    do_read(2, 16'h00FE, 3);
    do_read(0, 16'h0000, 1);

    // R8: abort inside command byte, then clean write
    cs_n = 1'b0; half(); partial_bits(5); half(); cs_n = 1'b1; half();
    tx_buf[0] = 8'h5C;
    do_write(0, 16'h0040, 1, "R8 write after header abort");
    do_read(0, 16'h0040, 1);

    // R8: abort inside second data byte
    begin
      int w0;
      logic [7:0] q;
      w0 = we_cnt;
      cs_n = 1'b0; half();
      xfer(8'h82, q); xfer(8'h50, q); xfer(8'h00, q);
      xfer(8'h6B, q);
      partial_bits(4);
      half(); cs_n = 1'b1; half();
      check(we_cnt - w0 == 1, "R8 partial byte dropped", we_cnt - w0, 1);
      exp_mem[8'h50] = 8'h6B;
      do_read(2, 16'h0050, 3);
    end

    // random mix
    for (int t = 0; t < 40; t++) begin
      bit wr;
      int cm1, nb;
      logic [15:0] a;
      wr  = 1'($urandom_range(0, 1));
      cm1 = int'($urandom_range(0, 7));
      nb  = cm1 + 1 + int'($urandom_range(0, 2));
      a   = {($urandom_range(0, 9) == 0) ? 8'h01 : 8'h00, 8'($urandom)};
      if (wr) begin
        for (int k = 0; k < nb; k++) tx_buf[k] = 8'($urandom);
        do_write(cm1, a, nb, "R5 random write strobes");
      end else begin
        do_read(cm1, a, nb);
      end
    end
    // final sweep through a burst covering random targets
    for (int b = 0; b < 256; b += 16) do_read(15, 16'(b), 16);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule